// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Enable Preamble

This block serialises characters onto a single output line for an asynchronous link. A character is framed by one low start bit and one high stop bit, and carries either 8 or 9 data bits. A control bit picks the length. In the longer format, the extra data bit comes from its own control bit and not from the data byte. The line rests at logic one. Each data bit goes out for exactly one interval of an external baud tick, which arrives once per bit time.

A host writes through one strobed port. A select input steers each write either to the one-character data holding register or to the control register. When the enable bit goes from off to on, one whole character time of idle ones is queued before anything else is sent. Two flags are visible at the ports. The empty flag means the holding register may be written. The done flag means the line has gone quiet with nothing left to send. Each flag has its own interrupt enable, and a single registered interrupt request combines the two.

Top module: `atx_serial_tx`

## Requirements
- R1: After reset `txd`=1, `tx_empty`=1, `tx_done`=1 and `irq`=0. Every control bit is 0, so the transmitter and both interrupt sources are off.
- R2: A write with `wr_ctl`=1 loads the control register from `wr_val`. Bit 0 is the enable, bit 1 is the mode (0 = 8 data bits, 1 = 9 data bits), bit 2 is the ninth data bit, bit 3 enables the empty interrupt and bit 4 enables the done interrupt.
- R3: In 8-bit mode a character is sent as a start bit 0, then data bits 0 to 7 in order starting with the LSB, then a stop bit 1. Each bit is held from one baud tick to the next, and control bit 2 has no effect.
- R4: In 9-bit mode control bit 2, sampled when the character starts, is sent after data bit 7 and before the stop bit, giving an 11-bit frame.
- R5: A 0-to-1 change of the enable queues one full character time of ones. The preamble is 10 baud intervals in 8-bit mode and 11 in 9-bit mode. It goes out before any pending data.
- R6: A data write (`wr_ctl`=0) clears `tx_empty`. The baud tick that starts the start bit moves the data into the shifter and sets `tx_empty`.
- R7: `tx_done` is cleared by a data write and by the start of any frame or preamble. It is set on the first baud tick after a stop bit or preamble has ended, provided the holding register is empty. The line is 1 while `tx_done` is 1.
- R8: While the enable is 0, written data stays pending and is not sent. `txd` stays 1 and `tx_done` stays 0.
- R9: Clearing the enable during a character lets that character, and any preamble already queued, finish in full.
- R10: If a data write and a shifter load fall in the same cycle, the previous byte is sent, the new byte is kept, and `tx_empty` stays 0.
- R11: `txd` changes only in cycles where `baud_tick` is 1.
- R12: `irq` is registered. It equals (empty flag AND bit 3) OR (done flag AND bit 4), as those values stood one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | Write strobe for the host port |
| wr_ctl | input | 1 | Write target: 1 = control register, 0 = data holding register |
| wr_val | input | DATA_W | Write value |
| baud_tick | input | 1 | One-cycle pulse at the bit rate |
| txd | output | 1 | Serial output line, idle high |
| tx_empty | output | 1 | Holding register may be written |
| tx_done | output | 1 | Line idle with nothing pending |
| irq | output | 1 | Combined interrupt request |

## Verification
A host data write can land in the same clock as the baud tick that moves the held byte into the shifter. In that cycle the empty flag is told to set and to clear, and the holding register is read and overwritten. The bench raises the strobe and the tick together. It passes if the old byte's start bit appears with `tx_empty` still low, and the new byte then follows back to back on the next tick. The same collision also clears the done flag twice in one cycle, and the bench checks it stays low throughout.

// File: rtl/atx_pkg.sv
package atx_pkg;
  // Control register image; packed order gives bit 0 = en ... bit 4 = ie_done
  typedef struct packed {
    logic ie_done;
    logic ie_empty;
    logic x8;
    logic nine;
    logic en;
  } atx_cfg_t;

  localparam int CTRL_W = $bits(atx_cfg_t);
endpackage

// File: rtl/atx_cfg.sv
module atx_cfg
  import atx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic              wr_ctl,
  input  logic [CTRL_W-1:0] wr_val,
  output atx_cfg_t          cfg_q,
  output logic              en_rise
);
  logic ctl_wr;
  assign ctl_wr  = wr_stb & wr_ctl;
  // Combinational so the shifter queues the preamble in the same edge as the write
  assign en_rise = ctl_wr & wr_val[0] & ~cfg_q.en;

  always_ff @(posedge clk) begin
    if (rst) cfg_q <= '0;
    else if (ctl_wr) cfg_q <= atx_cfg_t'(wr_val);
  end

  assert_ctl_load_R2: assert property (@(posedge clk) disable iff (rst)
    ctl_wr |=> (cfg_q == atx_cfg_t'($past(wr_val))));
endmodule

// File: rtl/atx_hold.sv
module atx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              data_wr,
  input  logic [DATA_W-1:0] wr_val,
  input  logic              take,
  output logic [DATA_W-1:0] hold_q,
  output logic              empty_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q  <= '0;
      empty_q <= 1'b1;
    end else begin
      if (take) empty_q <= 1'b1;
      // a write in the same cycle as a load wins the flag
      if (data_wr) begin
        hold_q  <= wr_val;
        empty_q <= 1'b0;
      end
    end
  end

  assert_write_clears_empty_R6: assert property (@(posedge clk) disable iff (rst)
    data_wr |=> !empty_q);
  assert_take_sets_empty_R6: assert property (@(posedge clk) disable iff (rst)
    (take && !data_wr) |=> empty_q);
  assert_collision_keeps_R10: assert property (@(posedge clk) disable iff (rst)
    (take && data_wr) |=> (!empty_q && hold_q == $past(wr_val)));
endmodule

// File: rtl/atx_shift.sv
module atx_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              en,
  input  logic              nine,
  input  logic              x8,
  input  logic              en_rise,
  input  logic              empty,
  input  logic              data_wr,
  input  logic [DATA_W-1:0] hold,
  output logic              take,
  output logic              line_q,
  output logic              done_q
);
  localparam int SH_W    = DATA_W + 2;          // data, optional ninth bit, stop
  localparam int CNT_MAX = DATA_W + 2;          // bits after the first of a long frame
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic [SH_W-1:0]  sh_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] frame_cnt;
  logic             pre_q;
  logic             slot;

  assign frame_cnt = nine ? CNT_W'(DATA_W + 2) : CNT_W'(DATA_W + 1);
  assign slot      = tick && (cnt_q == '0);
  assign take      = slot && !pre_q && en && !empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q <= 1'b1;
      sh_q   <= '1;
      cnt_q  <= '0;
      pre_q  <= 1'b0;
      done_q <= 1'b1;
    end else begin
      if (tick) begin
        if (cnt_q != '0) begin
          line_q <= sh_q[0];
          sh_q   <= {1'b1, sh_q[SH_W-1:1]};
          cnt_q  <= cnt_q - 1'b1;
        end else if (pre_q) begin
          line_q <= 1'b1;
          sh_q   <= '1;
          cnt_q  <= frame_cnt;
          pre_q  <= 1'b0;
          done_q <= 1'b0;
        end else if (take) begin
          line_q <= 1'b0;
          sh_q   <= {1'b1, (nine ? x8 : 1'b1), hold};
          cnt_q  <= frame_cnt;
          done_q <= 1'b0;
        end else begin
          line_q <= 1'b1;
          if (empty) done_q <= 1'b1;
        end
      end
      if (data_wr) done_q <= 1'b0;
      if (en_rise) pre_q  <= 1'b1;
    end
  end

  assert_line_on_tick_R11: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(line_q));
  assert_done_line_high_R7: assert property (@(posedge clk) disable iff (rst)
    done_q |-> line_q);
  assert_write_clears_done_R7: assert property (@(posedge clk) disable iff (rst)
    data_wr |=> !done_q);
  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(CNT_MAX));
  assert_start_low_R3: assert property (@(posedge clk) disable iff (rst)
    take |=> !line_q);
endmodule

// File: rtl/atx_irq.sv
module atx_irq (
  input  logic clk,
  input  logic rst,
  input  logic ie_empty,
  input  logic ie_done,
  input  logic empty,
  input  logic done,
  output logic irq_q
);
  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= (empty & ie_empty) | (done & ie_done);
  end

  assert_irq_masked_R12: assert property (@(posedge clk) disable iff (rst)
    (!ie_empty && !ie_done) |=> !irq_q);
  assert_irq_empty_R12: assert property (@(posedge clk) disable iff (rst)
    (ie_empty && empty) |=> irq_q);
endmodule

// File: rtl/atx_serial_tx.sv
module atx_serial_tx
  import atx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic              wr_ctl,
  input  logic [DATA_W-1:0] wr_val,
  input  logic              baud_tick,
  output logic              txd,
  output logic              tx_empty,
  output logic              tx_done,
  output logic              irq
);
  atx_cfg_t          cfg;
  logic              en_rise;
  logic              data_wr;
  logic              take;
  logic [DATA_W-1:0] hold;

  assign data_wr = wr_stb & ~wr_ctl;

  atx_cfg u_cfg (
    .clk     (clk),
    .rst     (rst),
    .wr_stb  (wr_stb),
    .wr_ctl  (wr_ctl),
    .wr_val  (wr_val[CTRL_W-1:0]),
    .cfg_q   (cfg),
    .en_rise (en_rise)
  );

  atx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk     (clk),
    .rst     (rst),
    .data_wr (data_wr),
    .wr_val  (wr_val),
    .take    (take),
    .hold_q  (hold),
    .empty_q (tx_empty)
  );

  atx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .tick    (baud_tick),
    .en      (cfg.en),
    .nine    (cfg.nine),
    .x8      (cfg.x8),
    .en_rise (en_rise),
    .empty   (tx_empty),
    .data_wr (data_wr),
    .hold    (hold),
    .take    (take),
    .line_q  (txd),
    .done_q  (tx_done)
  );

  atx_irq u_irq (
    .clk      (clk),
    .rst      (rst),
    .ie_empty (cfg.ie_empty),
    .ie_done  (cfg.ie_done),
    .empty    (tx_empty),
    .done     (tx_done),
    .irq_q    (irq)
  );
endmodule

// File: tb/atx_serial_tx_tb.sv
module atx_serial_tx_tb;
  localparam int CLK_NS = 10;
  // {nine, x8, data[7:0], expected frame bits in send order [10:0], length[3:0]}
  localparam logic [24:0] VECS [0:5] = '{
    {1'b0, 1'b0, 8'hA5, {1'b0, 1'b1, 8'hA5, 1'b0}, 4'd10},
    {1'b0, 1'b1, 8'h3C, {1'b0, 1'b1, 8'h3C, 1'b0}, 4'd10},
    {1'b1, 1'b1, 8'h00, {1'b1, 1'b1, 8'h00, 1'b0}, 4'd11},
    {1'b1, 1'b0, 8'hFF, {1'b1, 1'b0, 8'hFF, 1'b0}, 4'd11},
    {1'b0, 1'b0, 8'h01, {1'b0, 1'b1, 8'h01, 1'b0}, 4'd10},
    {1'b1, 1'b1, 8'h80, {1'b1, 1'b1, 8'h80, 1'b0}, 4'd11}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_stb = 1'b0;
  logic       wr_ctl = 1'b0;
  logic [7:0] wr_val = '0;
  logic       baud_tick = 1'b0;
  logic       txd, tx_empty, tx_done, irq;
  int         nchk = 0;
  int         nfail = 0;
  logic [10:0] fr;
  logic       prev;

  always #(CLK_NS/2) clk = ~clk;

  atx_serial_tx #(.DATA_W(8)) u_dut (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_ctl(wr_ctl), .wr_val(wr_val),
    .baud_tick(baud_tick), .txd(txd), .tx_empty(tx_empty), .tx_done(tx_done), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic ctl, input logic [7:0] v);
    @(negedge clk); wr_stb = 1'b1; wr_ctl = ctl; wr_val = v;
    @(negedge clk); wr_stb = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk); baud_tick = 1'b1;
    @(negedge clk); baud_tick = 1'b0;
  endtask

  // collect bits [from, len) of a frame, one per tick
  task automatic grab(input int from, input int len);
    for (int i = from; i < len; i++) begin
      tick();
      fr[i] = txd;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 txd", txd, 1); chk("R1 empty", tx_empty, 1);
    chk("R1 done", tx_done, 1); chk("R1 irq", irq, 0);
    tick(); chk("R1 disabled line idle", txd, 1);

    // R5 preamble alone: 10 ones, done set on the 11th tick
    wr(1'b1, 8'h01);
    tick(); chk("R5 preamble high", txd, 1); chk("R7 preamble clears done", tx_done, 0);
    for (int i = 2; i <= 10; i++) begin
      tick(); chk("R5 preamble high", txd, 1);
    end
    chk("R5 preamble still running", tx_done, 0);
    tick(); chk("R7 done after preamble", tx_done, 1);

    // R2 R3 R4 R6 vector table
    for (int v = 0; v < 6; v++) begin
      wr(1'b1, {3'b000, VECS[v][23], VECS[v][24], 1'b1});
      wr(1'b0, VECS[v][22:15]);
      chk("R6 write clears empty", tx_empty, 0); chk("R7 write clears done", tx_done, 0);
      fr = '0;
      tick(); fr[0] = txd;
      chk("R6 load sets empty", tx_empty, 1);
      grab(1, int'(VECS[v][3:0]));
      chk(VECS[v][24] ? "R4 nine-bit frame" : "R3 eight-bit frame", fr, VECS[v][14:4]);
      tick(); chk("R7 done after stop", tx_done, 1); chk("R3 idle high", txd, 1);
    end

    // R12 interrupts
    wr(1'b1, 8'h09); @(negedge clk); chk("R12 empty irq", irq, 1);
    wr(1'b0, 8'h55); @(negedge clk); chk("R12 irq drops with empty", irq, 0);
    wr(1'b1, 8'h11); @(negedge clk); chk("R12 done irq idle", irq, 0);
    fr = '0; grab(0, 10); chk("R3 frame 55", fr, {1'b0, 1'b1, 8'h55, 1'b0});
    tick(); @(negedge clk); chk("R12 done irq", irq, 1);
    wr(1'b1, 8'h01); @(negedge clk); chk("R12 masked", irq, 0);

    // R8 pending while disabled, then R5 preamble ahead of data
    wr(1'b1, 8'h00);
    wr(1'b0, 8'h3C);
    for (int i = 0; i < 3; i++) begin
      tick(); chk("R8 line idle", txd, 1); chk("R8 pending", tx_empty, 0); chk("R8 done low", tx_done, 0);
    end
    wr(1'b1, 8'h01);
    for (int i = 1; i <= 10; i++) begin
      tick(); chk("R5 preamble before data", txd, 1);
    end
    chk("R5 data waits", tx_empty, 0);
    fr = '0; tick(); fr[0] = txd; chk("R6 start after preamble", tx_empty, 1);
    grab(1, 10); chk("R8 frame 3C", fr, {1'b0, 1'b1, 8'h3C, 1'b0});
    tick(); chk("R7 done", tx_done, 1);

    // R9 disable during a character, R11 no change without tick
    wr(1'b0, 8'hF0);
    fr = '0; grab(0, 4);
    prev = txd;
    wr(1'b1, 8'h00);
    chk("R11 line stable without tick", txd, prev);
    grab(4, 10); chk("R9 char finishes", fr, {1'b0, 1'b1, 8'hF0, 1'b0});
    tick(); chk("R9 done after finish", tx_done, 1);
    // R9 queued preamble completes after disable
    wr(1'b1, 8'h01); wr(1'b1, 8'h00);
    tick(); chk("R9 preamble runs", tx_done, 0);
    for (int i = 2; i <= 10; i++) tick();
    chk("R9 preamble still running", tx_done, 0);
    tick(); chk("R9 preamble finished", tx_done, 1);

    // R10 write colliding with load
    wr(1'b1, 8'h01);
    for (int i = 1; i <= 11; i++) tick();
    chk("R7 idle before collision", tx_done, 1);
    wr(1'b0, 8'h81);
    @(negedge clk); wr_stb = 1'b1; wr_ctl = 1'b0; wr_val = 8'h7E; baud_tick = 1'b1;
    @(negedge clk); wr_stb = 1'b0; baud_tick = 1'b0;
    fr = '0; fr[0] = txd;
    chk("R10 start of old byte", txd, 0); chk("R10 empty stays low", tx_empty, 0);
    chk("R10 done low", tx_done, 0);
    grab(1, 10); chk("R10 old byte sent", fr, {1'b0, 1'b1, 8'h81, 1'b0});
    fr = '0; tick(); fr[0] = txd; chk("R10 new byte back to back", tx_empty, 1);
    grab(1, 10); chk("R10 new byte sent", fr, {1'b0, 1'b1, 8'h7E, 1'b0});
    tick(); chk("R7 done at end", tx_done, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end
endmodule